// File: doc/BRIEF.md
# Word Load/Store and Stack Access Sequencer

This block carries out the memory half of the data-transfer instructions of a small 32-bit integer core. It covers word loads, word stores, push and pop. The decoder hands it the 6-bit opcode, the values of the two named registers (the data register and the base register), the value of a third register for the indexed forms, the raw 16-bit immediate, and the 5-bit numbers of the data and base registers. From these the block forms a byte address and converts it to a word index. In the same cycle it drives a single-port, synchronous-read word memory. Two clock edges later it returns a registered load value and, for push and pop, the adjusted base value, each with its own write strobe.

Addresses are byte addresses, and the word index is the byte address divided by four and rounded toward minus infinity. An address that is negative or that falls beyond the memory depth raises an error and blocks every side effect. The block also drives the reset value that the register file should load into the stack register. That value is the highest byte address of the memory.

Top module: `lsu_stack_unit`

## Requirements
- R1: Opcode 32 (immediate form) and opcode 33 (indexed form) read the memory word at index floor((base + C) / 4). The word comes back on `ra_result` with `ra_we` high, and `rb_we` stays low.
- R2: Opcode 36 (immediate form) and opcode 37 (indexed form) drive `mem_we` high in the start cycle. The write goes to index floor((base + C) / 4) with `mem_wdata` equal to the data register, and both writeback strobes stay low.
- R3: Opcode 34 reads the word at index floor(base / 4) into the data register and returns base + C on `rb_result` with `rb_we` high.
- R4: Opcode 38 returns base + C on `rb_result` with `rb_we` high. It writes the data register to index floor((base + C) / 4), which is the adjusted address and not the old one.
- R5: Opcodes 33 and 37 take C from `rc_val`. All other opcodes take C from `imm16`, sign-extended from bit 15.
- R6: A start with a memory opcode is sampled at a clock edge. `done` is high for exactly one cycle, after the second edge counted from that one, and it carries that access's results. Starts may follow each other on consecutive cycles.
- R7: If the computed byte address is negative, or its word index is not below DEPTH, then `mem_we` stays low and `range_err` is high together with `done`. Both `ra_we` and `rb_we` stay low.
- R8: When opcode 34 names the same register number on `ra_sel` and `rb_sel`, the adjusted base value wins. `rb_we` is high and `ra_we` is low.
- R9: A start with any opcode other than 32, 33, 34, 36, 37 or 38 produces no memory write, no `done` and no writeback.
- R10: `stack_top` always equals 4*DEPTH-1. After reset `done`, `range_err`, `ra_we` and `rb_we` are low and both result buses are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Access request for the current cycle |
| opcode | input | 6 | Instruction opcode |
| ra_val | input | DATA_W | Value of the data register |
| rb_val | input | DATA_W | Value of the base register |
| rc_val | input | DATA_W | Register operand used by the indexed forms |
| imm16 | input | 16 | Raw immediate field |
| ra_sel | input | SEL_W | Number of the data register |
| rb_sel | input | SEL_W | Number of the base register |
| mem_addr | output | IDX_W | Word index to the memory |
| mem_we | output | 1 | Memory write enable |
| mem_wdata | output | DATA_W | Memory write data |
| mem_rdata | input | DATA_W | Memory read data, valid the cycle after the address |
| done | output | 1 | Access-complete pulse |
| range_err | output | 1 | Address out of range for the completed access |
| ra_we | output | 1 | Write `ra_result` to the data register |
| ra_result | output | DATA_W | Loaded word |
| rb_we | output | 1 | Write `rb_result` to the base register |
| rb_result | output | DATA_W | Adjusted base value |
| stack_top | output | DATA_W | Reset value for the stack register |

## Verification
The bench builds the block with DEPTH = 16 words, so the address space is only 64 bytes. At that size the last valid word (byte 63), the first index past the end (byte 64) and small negative byte addresses are all reached by ordinary immediates and by random base values. It also makes a push followed by a pop, and a store followed by a load of the same word, land on the same words often, and it lets the floor rounding of negative and unaligned byte addresses be checked directly.

// File: rtl/lsu_pkg.sv
package lsu_pkg;

  localparam logic [5:0] OPC_LD_IMM = 6'd32;
  localparam logic [5:0] OPC_LD_REG = 6'd33;
  localparam logic [5:0] OPC_POP    = 6'd34;
  localparam logic [5:0] OPC_ST_IMM = 6'd36;
  localparam logic [5:0] OPC_ST_REG = 6'd37;
  localparam logic [5:0] OPC_PUSH   = 6'd38;

  typedef enum logic [2:0] {
    ACC_NONE,
    ACC_LOAD,
    ACC_STORE,
    ACC_POP,
    ACC_PUSH
  } acc_kind_e;

  function automatic acc_kind_e classify(logic [5:0] op);
    case (op)
      OPC_LD_IMM, OPC_LD_REG: return ACC_LOAD;
      OPC_ST_IMM, OPC_ST_REG: return ACC_STORE;
      OPC_POP:                return ACC_POP;
      OPC_PUSH:               return ACC_PUSH;
      default:                return ACC_NONE;
    endcase
  endfunction

  function automatic logic uses_reg_operand(logic [5:0] op);
    return (op == OPC_LD_REG) || (op == OPC_ST_REG);
  endfunction

endpackage

// File: rtl/lsu_addr_gen.sv
module lsu_addr_gen
  import lsu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 256,
  parameter int IMM_W  = 16,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic [5:0]        opcode,
  input  logic [DATA_W-1:0] rb_val,
  input  logic [DATA_W-1:0] rc_val,
  input  logic [IMM_W-1:0]  imm16,
  output acc_kind_e         kind,
  output logic [DATA_W-1:0] base_next,
  output logic [IDX_W-1:0]  word_idx,
  output logic              addr_err
);
  localparam int SW  = DATA_W + 1;
  localparam int WIW = SW - 2;
  localparam logic [WIW-1:0] DEPTH_V = WIW'(DEPTH);

  function automatic logic signed [SW-1:0] widen(logic [DATA_W-1:0] v);
    return $signed({v[DATA_W-1], v});
  endfunction

  function automatic logic [DATA_W-1:0] sext_imm(logic [IMM_W-1:0] v);
    return {{(DATA_W-IMM_W){v[IMM_W-1]}}, v};
  endfunction

  logic [DATA_W-1:0]     c_val;
  logic signed [SW-1:0]  sum;
  logic signed [SW-1:0]  eff_addr;
  logic [WIW-1:0]        full_idx;

  always_comb begin
    kind      = classify(opcode);
    c_val     = uses_reg_operand(opcode) ? rc_val : sext_imm(imm16);
    sum       = widen(rb_val) + widen(c_val);
    eff_addr  = (kind == ACC_POP) ? widen(rb_val) : sum;
    full_idx  = eff_addr[SW-1:2];
    addr_err  = eff_addr[SW-1] || (full_idx >= DEPTH_V);
    word_idx  = full_idx[IDX_W-1:0];
    base_next = sum[DATA_W-1:0];
  end

endmodule

// File: rtl/lsu_pipe.sv
module lsu_pipe
  import lsu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int SEL_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  acc_kind_e         kind,
  input  logic              addr_err,
  input  logic [SEL_W-1:0]  ra_sel,
  input  logic [SEL_W-1:0]  rb_sel,
  input  logic [DATA_W-1:0] base_next,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              done,
  output logic              range_err,
  output logic              ra_we,
  output logic [DATA_W-1:0] ra_result,
  output logic              rb_we,
  output logic [DATA_W-1:0] rb_result
);
  logic              s1_valid;
  acc_kind_e         s1_kind;
  logic              s1_err;
  logic              s1_alias;
  logic [DATA_W-1:0] s1_base;

  logic ld_wb_ev;
  logic base_wb_ev;

  always_comb begin
    ld_wb_ev   = s1_valid && !s1_err &&
                 ((s1_kind == ACC_LOAD) || ((s1_kind == ACC_POP) && !s1_alias));
    base_wb_ev = s1_valid && !s1_err &&
                 ((s1_kind == ACC_POP) || (s1_kind == ACC_PUSH));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s1_kind  <= ACC_NONE;
      s1_err   <= 1'b0;
      s1_alias <= 1'b0;
      s1_base  <= '0;
    end else begin
      s1_valid <= accept;
      s1_kind  <= kind;
      s1_err   <= addr_err;
      s1_alias <= (ra_sel == rb_sel);
      s1_base  <= base_next;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done      <= 1'b0;
      range_err <= 1'b0;
      ra_we     <= 1'b0;
      rb_we     <= 1'b0;
      ra_result <= '0;
      rb_result <= '0;
    end else begin
      done      <= s1_valid;
      range_err <= s1_valid && s1_err;
      ra_we     <= ld_wb_ev;
      rb_we     <= base_wb_ev;
      if (ld_wb_ev)   ra_result <= mem_rdata;
      if (base_wb_ev) rb_result <= s1_base;
    end
  end

  AST_ERR_BLOCKS_WB: assert property (@(posedge clk) disable iff (!rst_n)
    range_err |-> (!ra_we && !rb_we)); // R7

  AST_ALIAS_BASE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_valid && !s1_err && s1_kind == ACC_POP && s1_alias) |=> (rb_we && !ra_we)); // R8

  AST_LOAD_NO_BASE: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_valid && s1_kind == ACC_LOAD) |=> !rb_we); // R1

endmodule

// File: rtl/lsu_stack_unit.sv
module lsu_stack_unit
  import lsu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 256,
  parameter int SEL_W  = 5,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [5:0]        opcode,
  input  logic [DATA_W-1:0] ra_val,
  input  logic [DATA_W-1:0] rb_val,
  input  logic [DATA_W-1:0] rc_val,
  input  logic [15:0]       imm16,
  input  logic [SEL_W-1:0]  ra_sel,
  input  logic [SEL_W-1:0]  rb_sel,
  output logic [IDX_W-1:0]  mem_addr,
  output logic              mem_we,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              done,
  output logic              range_err,
  output logic              ra_we,
  output logic [DATA_W-1:0] ra_result,
  output logic              rb_we,
  output logic [DATA_W-1:0] rb_result,
  output logic [DATA_W-1:0] stack_top
);
  localparam logic [DATA_W-1:0] TOP_BYTE = DATA_W'(DEPTH * 4 - 1);

  acc_kind_e         kind;
  logic [DATA_W-1:0] base_next;
  logic [IDX_W-1:0]  word_idx;
  logic              addr_err;
  logic              accept;
  logic              writes_mem;

  lsu_addr_gen #(.DATA_W(DATA_W), .DEPTH(DEPTH), .IMM_W(16)) u_agen (
    .opcode    (opcode),
    .rb_val    (rb_val),
    .rc_val    (rc_val),
    .imm16     (imm16),
    .kind      (kind),
    .base_next (base_next),
    .word_idx  (word_idx),
    .addr_err  (addr_err)
  );

  always_comb begin
    accept     = start && (kind != ACC_NONE);
    writes_mem = (kind == ACC_STORE) || (kind == ACC_PUSH);
    mem_we     = accept && writes_mem && !addr_err;
    mem_addr   = word_idx;
    mem_wdata  = ra_val;
    stack_top  = TOP_BYTE;
  end

  lsu_pipe #(.DATA_W(DATA_W), .SEL_W(SEL_W)) u_pipe (
    .clk       (clk),
    .rst_n     (rst_n),
    .accept    (accept),
    .kind      (kind),
    .addr_err  (addr_err),
    .ra_sel    (ra_sel),
    .rb_sel    (rb_sel),
    .base_next (base_next),
    .mem_rdata (mem_rdata),
    .done      (done),
    .range_err (range_err),
    .ra_we     (ra_we),
    .ra_result (ra_result),
    .rb_we     (rb_we),
    .rb_result (rb_result)
  );

  AST_DONE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> ##1 done); // R6

  AST_NO_WRITE_ON_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> !addr_err); // R7

  AST_IGNORED_OPCODE: assert property (@(posedge clk) disable iff (!rst_n)
    (start && kind == ACC_NONE) |-> !mem_we); // R9

  AST_LOAD_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == ACC_LOAD || kind == ACC_POP) |-> !mem_we); // R2

endmodule

// File: tb/lsu_stack_unit_test.sv
module lsu_stack_unit_test;
  localparam int DW  = 32;
  localparam int DEP = 16;
  localparam int IW  = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [5:0]    opcode = '0;
  logic [DW-1:0] ra_val = '0, rb_val = '0, rc_val = '0;
  logic [15:0]   imm16 = '0;
  logic [4:0]    ra_sel = '0, rb_sel = '0;
  logic [IW-1:0] mem_addr;
  logic          mem_we;
  logic [DW-1:0] mem_wdata;
  logic [DW-1:0] mem_rdata = '0;
  logic          done, range_err, ra_we, rb_we;
  logic [DW-1:0] ra_result, rb_result, stack_top;

  int n_vec = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  lsu_stack_unit #(.DATA_W(DW), .DEPTH(DEP), .SEL_W(5)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode),
    .ra_val(ra_val), .rb_val(rb_val), .rc_val(rc_val), .imm16(imm16),
    .ra_sel(ra_sel), .rb_sel(rb_sel), .mem_addr(mem_addr), .mem_we(mem_we),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .done(done),
    .range_err(range_err), .ra_we(ra_we), .ra_result(ra_result),
    .rb_we(rb_we), .rb_result(rb_result), .stack_top(stack_top)
  );

  logic [DW-1:0] ram [DEP];
  initial for (int i = 0; i < DEP; i++) ram[i] = '0;
  always @(posedge clk) begin
    if (mem_we) ram[mem_addr] <= mem_wdata;
    mem_rdata <= ram[mem_addr];
  end

  typedef struct {
    bit done, err, rawe, rbwe;
    logic [DW-1:0] rav, rbv;
    string tag;
  } exp_t;

  exp_t q[$];
  longint refm[DEP];

  task automatic chk(bit ok, string tag, string what, longint act, longint exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic step(bit go, int op, logic [DW-1:0] ra, logic [DW-1:0] rb,
                      logic [DW-1:0] rc, logic [15:0] imm, int as, int bs);
    exp_t e;
    longint c, sum, addr, idx;
    bit ld, st, pp, ps, err, mwe;
    start = go; opcode = 6'(op); ra_val = ra; rb_val = rb; rc_val = rc;
    imm16 = imm; ra_sel = 5'(as); rb_sel = 5'(bs);
    ld = go && (op == 32 || op == 33);
    st = go && (op == 36 || op == 37);
    pp = go && (op == 34);
    ps = go && (op == 38);
    c    = (op == 33 || op == 37) ? longint'($signed(rc)) : longint'($signed(imm));
    sum  = longint'($signed(rb)) + c;
    addr = pp ? longint'($signed(rb)) : sum;
    idx  = addr >>> 2;
    err  = (addr < 0) || (idx >= DEP);
    e.done = ld || st || pp || ps;
    e.err  = e.done && err;
    e.tag  = !e.done ? "R9" : err ? "R7" : (op == 33 || op == 37) ? "R5" :
             ld ? "R1" : st ? "R2" : (pp && as == bs) ? "R8" : pp ? "R3" : "R4";
    e.rawe = !err && (ld || (pp && as != bs));
    e.rbwe = !err && (pp || ps);
    e.rav  = e.rawe ? DW'(refm[idx]) : '0;
    e.rbv  = DW'(sum);
    mwe    = (st || ps) && !err;
    #1;
    chk(mem_we == mwe, e.tag, "mem_we", longint'(mem_we), longint'(mwe));
    if (mwe) begin
      chk(mem_addr == IW'(idx), e.tag, "mem_addr", longint'(mem_addr), idx);
      chk(mem_wdata == ra, e.tag, "mem_wdata", longint'(mem_wdata), longint'(ra));
      refm[idx] = longint'(ra);
    end
    q.push_back(e);
    @(posedge clk); #1;
    e = q.pop_front();
    chk(done == e.done, e.done ? "R6" : e.tag, "done", longint'(done), longint'(e.done));
    chk(range_err == e.err, "R7", "range_err", longint'(range_err), longint'(e.err));
    if (e.done) begin
      chk(ra_we == e.rawe, e.tag, "ra_we", longint'(ra_we), longint'(e.rawe));
      chk(rb_we == e.rbwe, e.tag, "rb_we", longint'(rb_we), longint'(e.rbwe));
      if (e.rawe) chk(ra_result == e.rav, e.tag, "ra_result", longint'(ra_result), longint'(e.rav));
      if (e.rbwe) chk(rb_result == e.rbv, e.tag, "rb_result", longint'(rb_result), longint'(e.rbv));
    end else begin
      chk(!ra_we && !rb_we, e.tag, "writeback while idle", longint'({ra_we, rb_we}), 0);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    #(4 * 200000);
    n_bad++;
    $display("FAIL watchdog: actual hung expected finished");
    finish_run();
  end

  initial begin
    exp_t idle;
    for (int i = 0; i < DEP; i++) refm[i] = 0;
    idle.done = 0; idle.err = 0; idle.rawe = 0; idle.rbwe = 0;
    idle.rav = '0; idle.rbv = '0; idle.tag = "R6";
    q.push_back(idle);
    repeat (3) @(posedge clk);
    #1;
    // R10: reset values and stack register seed
    chk(stack_top == DW'(DEP * 4 - 1), "R10", "stack_top", longint'(stack_top), DEP * 4 - 1);
    chk(!done && !range_err, "R10", "done/err at reset", longint'({done, range_err}), 0);
    chk(!ra_we && !rb_we, "R10", "we at reset", longint'({ra_we, rb_we}), 0);
    chk(ra_result == 0 && rb_result == 0, "R10", "results at reset",
        longint'(ra_result | rb_result), 0);
    rst_n = 1'b1;
    @(posedge clk); #1;

    step(1, 38, 32'hAAAA0001, 64, 0, 16'hFFFC, 1, 30);   // R4 push to word 15
    step(1, 38, 32'hAAAA0002, 60, 0, 16'hFFFC, 2, 30);   // R4 push to word 14
    step(1, 32, 0, 56, 0, 16'd4, 3, 4);                  // R1 load word 15
    step(1, 33, 0, 0, 56, 16'd0, 3, 4);                  // R5 indexed load word 14
    step(1, 34, 0, 56, 0, 16'd4, 1, 30);                 // R3 pop word 14
    step(1, 34, 0, 60, 0, 16'd4, 30, 30);                // R8 aliased pop
    step(1, 36, 32'h1234, 3, 0, 16'd5, 6, 7);            // R2 store, byte 8
    step(1, 32, 0, 8, 0, 16'd0, 6, 7);                   // R2 read back
    step(1, 37, 32'h5678, 10, 32'hFFFFFFFE, 16'd0, 6, 7); // R5 indexed store
    step(1, 32, 0, 11, 0, 16'hFFFF, 6, 7);               // R1 unaligned read back
    step(1, 32, 0, 64, 0, 16'd0, 1, 2);                  // R7 past the end
    step(1, 32, 0, 63, 0, 16'd0, 1, 2);                  // R1 last byte
    step(1, 36, 32'hDEAD, 0, 0, 16'hFFFF, 1, 2);         // R7 negative store
    step(1, 38, 32'hBEEF, 2, 0, 16'hFFFC, 1, 2);         // R7 push below zero
    step(1, 34, 0, 64, 0, 16'd4, 1, 2);                  // R7 pop past the end
    step(1, 32, 0, 0, 8, 16'hFFFC, 1, 2);                // R5 immediate wins
    step(1, 33, 0, 0, 8, 16'hFFFC, 1, 2);                // R5 register wins
    step(1, 0, 32'h77, 0, 0, 16'd0, 1, 2);               // R9
    step(1, 35, 32'h77, 0, 0, 16'd0, 1, 2);              // R9
    step(1, 40, 32'h77, 0, 0, 16'd0, 1, 2);              // R9
    step(1, 63, 32'h77, 0, 0, 16'd0, 1, 2);              // R9
    step(0, 36, 32'h99, 0, 0, 16'd0, 1, 2);              // no start
    for (int k = 0; k < 8; k++) step(1, 32, 0, 0, 0, 16'(k * 4), 1, 2);

    for (int k = 0; k < 600; k++) begin
      int ops[9] = '{32, 33, 34, 36, 37, 38, 0, 50, 38};
      int op = ops[$urandom_range(0, 8)];
      logic [DW-1:0] rb = DW'($signed($urandom_range(0, 80)) - 8);
      logic [15:0] im = 16'($signed($urandom_range(0, 16)) - 8);
      logic [DW-1:0] rc = DW'($signed($urandom_range(0, 16)) - 8);
      step($urandom_range(0, 7) != 0, op, $urandom, rb, rc, im,
           $urandom_range(0, 3), $urandom_range(0, 3));
    end
    step(0, 0, 0, 0, 0, 16'd0, 0, 0);
    finish_run();
  end

endmodule